// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous pipelined burst memory. Each cycle it reads a set of active-low strobes. Two address-status strobes can start a burst: one for the processor and one for the controller. A third strobe advances the burst. On a load, the block captures the external address into a base register. After that, only the two low bits change, moving through four beats. The upper bits stay as loaded until the next load, however many times the burst wraps.

A static order input picks one of two beat orders:

- Interleaved order XORs a beat counter into the starting low bits.
- Linear order adds the beat counter to the starting low bits, modulo four.

The block also reports a one-cycle flag after each new burst start, and whether a burst is active. Chip-enable qualification is computed outside and arrives as a single input. The primary chip enable also arrives separately, because it decides whether the processor strobe counts.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next values are `word_addr` = 0, `burst_start` = 0 and `burst_active` = 0.
- R2: If `ctrl_stb_n` is 0 and `sel_ok` is 1 at an edge, then after that edge `word_addr` equals the `ext_addr` sampled there, and `burst_active` is 1.
- R3: `proc_stb_n` = 0 counts as a load request only when `prim_ce_n` = 0. When `prim_ce_n` = 1 it is ignored, and the cycle behaves as though the strobe were 1.
- R4: If a load request is present while `sel_ok` = 0, the edge ends any burst (`burst_active` becomes 0) and leaves `word_addr` unchanged.
- R5: With `order_sel` = 1 (interleaved), beat k (k = 0..3) has low two bits equal to the start low bits XOR k.
- R6: With `order_sel` = 0 (linear), beat k has low two bits equal to (start low bits + k) mod 4.
- R7: Upper bits `word_addr[AW-1:2]` change only on a load. An advance after beat 3 returns to beat 0 of the same burst.
- R8: With no load request, a burst active and `adv_n` = 1, `word_addr` is held.
- R9: With no burst active and no load request, `adv_n` = 0 has no effect on `word_addr` or `burst_active`.
- R10: `burst_start` is 1 for exactly the cycle after a qualified load, and 0 otherwise.
- R11: A qualified load takes priority over a simultaneous `adv_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | AW | External word address captured on load |
| proc_stb_n | input | 1 | Processor address-status strobe, active low |
| ctrl_stb_n | input | 1 | Controller address-status strobe, active low |
| adv_n | input | 1 | Burst advance strobe, active low |
| prim_ce_n | input | 1 | Primary chip enable, active low |
| sel_ok | input | 1 | All chip enables qualify (1 = selected) |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order (static) |
| word_addr | output | AW | Current burst word address |
| burst_start | output | 1 | High for the cycle after a new burst load |
| burst_active | output | 1 | A burst is in progress |

## Verification
The hardest case to reach is a burst that has wrapped past its fourth beat after being suspended part-way. The upper bits must still hold while the low bits return to the start. A processor strobe blocked by the primary enable must not disturb that burst. The directed phases build this case: a load, advances mixed with held cycles, five or more advances, and then an ignored processor strobe on top. A long stretch of random strobes in each order then runs against a behavioural model. Start addresses in that stretch take every low-bit value.

// File: rtl/bas_pkg.sv
package bas_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_LOAD  = 3'd1,
        CMD_STEP  = 3'd2,
        CMD_HOLD  = 3'd3,
        CMD_DESEL = 3'd4
    } bas_cmd_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } bas_order_e;

    typedef struct packed {
        logic [BEAT_W-1:0] beat;
        logic              active;
        logic              start;
    } bas_state_t;

    // Low address bits for a given beat of a burst
    function automatic logic [BEAT_W-1:0] beat_low(
        input bas_order_e        ord,
        input logic [BEAT_W-1:0] first,
        input logic [BEAT_W-1:0] beat
    );
        if (ord == ORD_INTERLEAVE)
            return first ^ beat;
        else
            return first + beat;
    endfunction

endpackage

// File: rtl/bas_decode.sv
module bas_decode
    import bas_pkg::*;
(
    input  logic     proc_stb_n,
    input  logic     ctrl_stb_n,
    input  logic     adv_n,
    input  logic     prim_ce_n,
    input  logic     sel_ok,
    input  logic     active,
    output bas_cmd_e cmd
);

    logic proc_req;
    logic load_req;

    // Processor strobe only counts with the primary enable asserted
    assign proc_req = ~proc_stb_n & ~prim_ce_n;
    assign load_req = proc_req | ~ctrl_stb_n;

    always_comb begin
        if (load_req)
            cmd = sel_ok ? CMD_LOAD : CMD_DESEL;
        else if (!active)
            cmd = CMD_IDLE;
        else if (!adv_n)
            cmd = CMD_STEP;
        else
            cmd = CMD_HOLD;
    end

endmodule

// File: rtl/bas_counter.sv
module bas_counter
    import bas_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  bas_cmd_e      cmd,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] base_q,
    output bas_state_t    st_q
);

    bas_state_t    st_d;
    logic [AW-1:0] base_d;

    always_comb begin
        st_d       = st_q;
        base_d     = base_q;
        st_d.start = 1'b0;
        unique case (cmd)
            CMD_LOAD: begin
                base_d      = ext_addr;
                st_d.beat   = '0;
                st_d.active = 1'b1;
                st_d.start  = 1'b1;
            end
            CMD_STEP:  st_d.beat   = st_q.beat + 1'b1;
            CMD_DESEL: st_d.active = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            st_q   <= '0;
        end else begin
            base_q <= base_d;
            st_q   <= st_d;
        end
    end

endmodule

// File: rtl/bas_addr_map.sv
module bas_addr_map
    import bas_pkg::*;
#(
    parameter int AW = 17
) (
    input  bas_order_e        ord,
    input  logic [AW-1:0]     base,
    input  logic [BEAT_W-1:0] beat,
    output logic [AW-1:0]     word_addr
);

    localparam int UW = AW - BEAT_W;

    generate
        if (UW > 0) begin : g_upper
            assign word_addr[AW-1:BEAT_W] = base[AW-1:BEAT_W];
        end
    endgenerate

    assign word_addr[BEAT_W-1:0] = beat_low(ord, base[BEAT_W-1:0], beat);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ext_addr,
    input  logic          proc_stb_n,
    input  logic          ctrl_stb_n,
    input  logic          adv_n,
    input  logic          prim_ce_n,
    input  logic          sel_ok,
    input  logic          order_sel,
    output logic [AW-1:0] word_addr,
    output logic          burst_start,
    output logic          burst_active
);

    bas_cmd_e      cmd;
    bas_state_t    st_q;
    logic [AW-1:0] base_q;
    bas_order_e    ord;

    assign ord = bas_order_e'(order_sel);

    bas_decode u_decode (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .adv_n      (adv_n),
        .prim_ce_n  (prim_ce_n),
        .sel_ok     (sel_ok),
        .active     (st_q.active),
        .cmd        (cmd)
    );

    bas_counter #(.AW(AW)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .ext_addr (ext_addr),
        .base_q   (base_q),
        .st_q     (st_q)
    );

    bas_addr_map #(.AW(AW)) u_map (
        .ord       (ord),
        .base      (base_q),
        .beat      (st_q.beat),
        .word_addr (word_addr)
    );

    assign burst_start  = st_q.start;
    assign burst_active = st_q.active;

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] ext_addr,
    input logic          proc_stb_n,
    input logic          ctrl_stb_n,
    input logic          adv_n,
    input logic          prim_ce_n,
    input logic          sel_ok,
    input logic [AW-1:0] word_addr,
    input logic          burst_start,
    input logic          burst_active
);

    logic req;
    assign req = ~ctrl_stb_n | (~proc_stb_n & ~prim_ce_n);

    assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_stb_n && sel_ok) |=> (word_addr == $past(ext_addr)) && burst_active);

    assert_proc_blocked_R3: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && prim_ce_n && ctrl_stb_n) |=> !burst_start);

    assert_desel_R4: assert property (@(posedge clk) disable iff (rst)
        (req && !sel_ok) |=> !burst_active && $stable(word_addr));

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(word_addr[AW-1:2]));

    assert_suspend_R8: assert property (@(posedge clk) disable iff (rst)
        (!req && adv_n) |=> $stable(word_addr));

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!req && !burst_active) |=> !burst_active && $stable(word_addr));

    assert_start_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        !(req && sel_ok) |=> !burst_start);

endmodule

bind burst_addr_seq bas_checker #(.AW(AW)) u_bas_checker (
    .clk          (clk),
    .rst          (rst),
    .ext_addr     (ext_addr),
    .proc_stb_n   (proc_stb_n),
    .ctrl_stb_n   (ctrl_stb_n),
    .adv_n        (adv_n),
    .prim_ce_n    (prim_ce_n),
    .sel_ok       (sel_ok),
    .word_addr    (word_addr),
    .burst_start  (burst_start),
    .burst_active (burst_active)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          proc_stb_n = 1'b1;
    logic          ctrl_stb_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          prim_ce_n = 1'b1;
    logic          sel_ok = 1'b0;
    logic          order_sel = 1'b1;
    logic [AW-1:0] word_addr;
    logic          burst_start;
    logic          burst_active;

    int checks = 0;
    int failures = 0;

    // reference model state
    int m_base = 0;
    int m_beat = 0;
    bit m_act = 0;
    bit m_start = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.AW(AW)) u_burst_addr_seq (
        .clk          (clk),
        .rst          (rst),
        .ext_addr     (ext_addr),
        .proc_stb_n   (proc_stb_n),
        .ctrl_stb_n   (ctrl_stb_n),
        .adv_n        (adv_n),
        .prim_ce_n    (prim_ce_n),
        .sel_ok       (sel_ok),
        .order_sel    (order_sel),
        .word_addr    (word_addr),
        .burst_start  (burst_start),
        .burst_active (burst_active)
    );

    function automatic int exp_word();
        int lo;
        int first;
        first = m_base % 4;
        if (order_sel) lo = first ^ m_beat;
        else           lo = (first + m_beat) % 4;
        return (m_base / 4) * 4 + lo;
    endfunction

    task automatic model_edge();
        bit req;
        if (rst) begin
            m_base = 0; m_beat = 0; m_act = 0; m_start = 0;
            return;
        end
        req = !ctrl_stb_n || (!proc_stb_n && !prim_ce_n);
        if (req) begin
            if (sel_ok) begin
                m_base = int'(ext_addr); m_beat = 0; m_act = 1; m_start = 1;
            end else begin
                m_act = 0; m_start = 0;
            end
        end else begin
            m_start = 0;
            if (m_act && !adv_n) m_beat = (m_beat + 1) % 4;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(word_addr) != exp_word() || burst_start != m_start || burst_active != m_act) begin
            failures++;
            $display("FAIL %s: addr=%h start=%0d active=%0d expected addr=%h start=%0d active=%0d",
                     tag, word_addr, burst_start, burst_active, exp_word(), m_start, m_act);
        end
    endtask

    // drive at negedge, advance model at posedge, compare at next negedge
    task automatic cyc(input string tag, input bit p, input bit c, input bit a,
                       input bit pce, input bit ok, input int addr);
        proc_stb_n = p; ctrl_stb_n = c; adv_n = a; prim_ce_n = pce; sel_ok = ok;
        ext_addr = AW'(addr);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc("R1", 1, 1, 0, 1, 1, 'h1234);
        cyc("R1", 1, 1, 0, 1, 1, 'h1234);
        rst = 1'b0;

        // interleaved burst from low bits 10, with a suspend and a wrap
        order_sel = 1'b1;
        cyc("R2", 1, 0, 1, 1, 1, 'h0ABE);
        cyc("R5", 1, 1, 0, 1, 1, 'h1FFFF);
        cyc("R8", 1, 1, 1, 1, 1, 'h00000);
        cyc("R5", 1, 1, 0, 1, 1, 'h00000);
        cyc("R5", 1, 1, 0, 1, 1, 'h00000);
        cyc("R7", 1, 1, 0, 1, 1, 'h00000);
        cyc("R7", 1, 1, 0, 1, 1, 'h00000);
        // processor strobe blocked by primary enable
        cyc("R3", 0, 1, 1, 1, 1, 'h15555);
        cyc("R3", 0, 1, 0, 1, 1, 'h15555);

        // linear burst via processor strobe
        order_sel = 1'b0;
        cyc("R3", 0, 1, 1, 0, 1, 'h0F0E);
        for (int k = 0; k < 5; k++) cyc("R6", 1, 1, 0, 1, 1, 'h0);

        // load beats an advance
        cyc("R11", 1, 0, 0, 1, 1, 'h13);
        cyc("R10", 1, 1, 0, 1, 1, 'h0);

        // deselect, then advances do nothing
        cyc("R4", 1, 0, 0, 1, 0, 'h777);
        cyc("R9", 1, 1, 0, 1, 1, 'h888);
        cyc("R9", 1, 1, 0, 1, 1, 'h999);
        cyc("R4", 0, 1, 0, 0, 0, 'h555);

        // random strobes against the model in each order
        for (int ph = 0; ph < 2; ph++) begin
            order_sel = ph[0];
            for (int n = 0; n < 400; n++) begin
                bit rp, rc, ra, rpce, rok;
                rp   = ($urandom % 5) != 0;
                rc   = ($urandom % 6) != 0;
                ra   = ($urandom % 3) == 0;
                rpce = $urandom % 2;
                rok  = ($urandom % 8) != 0;
                cyc(ph == 0 ? "R6" : "R5", rp, rc, ra, rpce, rok, int'($urandom % (1 << AW)));
            end
        end

        rst = 1'b1;
        cyc("R1", 1, 1, 0, 1, 1, 'h3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule